// File: doc/BRIEF.md
# DDR Command Timing Monitor

This block watches the command bus between a DDR SDRAM controller and its memory devices and reports every command that breaks a protocol spacing rule. On each rising clock edge with chip select low it decodes the command from the row strobe, column strobe and write enable lines. It keeps an open or idle state for each of four banks together with a set of down-counting timers per bank, plus a few timers shared by all banks. Each rule has its own bit in a violation vector, and a single error strobe marks any cycle in which at least one bit is set.

All device minimums are parameters in picoseconds and are converted to whole clock cycles by rounding up. The tCK period parameter also selects the write-to-precharge variant. Burst length and CAS latency are run-time configuration inputs, because the read/write turnaround and precharge spacings depend on them. The monitor has no side effects on the bus. It is meant to sit beside a controller in simulation or on silicon debug logic.

In this brief, the spacing k between two commands is the number of clock edges from the first command to the second. A rule with minimum M is violated when k < M. With the default parameters (tCK 7.5 ns, tRCD 20, tRP 20, tRAS 45, tRC 67.5, tRRD 15, tWR 15 ns, mode-set gap 2) the minimums in cycles are: RCD 3, RP 3, RAS 6, RC 9, RRD 2, WR 2, DAL 5, MRD 2.

Top module: `ddr_cmd_timing_mon`

## Requirements
- R1: While cs_n is high the command lines are ignored and produce no flag. All timers keep counting during such cycles.
- R2: The command is {ras_n,cas_n,we_n}: 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op. The bank is {ba[1],ba[0]}. Violation bits are: 0 RCD, 1 RP, 2 RAS, 3 RC, 4 RRD, 5 write-to-precharge, 6 read-to-precharge, 7 write-to-read, 8 read-to-write, 9 mode-set gap, 10 illegal state, 11 auto-precharge write delay. The flags for a command edge appear on viol_o in the cycle that follows that edge, and err_o is high in exactly those cycles in which viol_o is nonzero.
- R3: A read or write to an open bank less than RCD cycles after that bank's activate sets bit 0.
- R4: An activate sets bit 1 if it comes less than RP cycles after an explicit precharge of that bank. It also sets bit 1 if it comes less than BL/2+RP cycles after a read with auto-precharge to that bank.
- R5: A precharge that closes a bank less than RAS cycles after its activate sets bit 2. An activate to a bank whose RAS window is still running also sets bit 2.
- R6: Two activates to the same bank less than RC cycles apart set bit 3.
- R7: An activate less than RRD cycles after an activate to a different bank sets bit 4. Two activates to the same bank never set bit 4.
- R8: A precharge sets bit 5 if it comes less than 3+BL/2 cycles after a write to that bank (4+BL/2 when tCK is below the fast-grade threshold). It sets bit 6 if it comes less than BL/2 cycles after a read to that bank.
- R9: A read less than 2+BL/2 cycles after a write to any bank sets bit 7. A write less than ceil(CL)+BL/2 cycles after a read sets bit 8. cfg_cl25=1 selects CL 2.5 and 0 selects CL 2. cfg_bl 01, 10 and 11 select BL 2, 4 and 8, and 00 selects BL 2.
- R10: Any command other than no-op less than MRD cycles after a mode set sets bit 9.
- R11: An activate less than 1+BL/2+DAL cycles after a write with auto-precharge to that bank sets bit 11. DAL is ceil(tWR/tCK)+ceil(tRP/tCK).
- R12: A precharge with a10 high closes every open bank, and with a10 low closes only the addressed bank. A read or write with a10 high closes its bank.
- R13: A read or write to an idle bank, or an activate to an open bank, sets bit 10 and changes no bank state.
- R14: After reset all banks are idle and all timers have expired. Timers stop at zero, so a long idle stretch never causes a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low marks a valid command |
| ras_n | input | 1 | Row strobe command line |
| cas_n | input | 1 | Column strobe command line |
| we_n | input | 1 | Write enable command line |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Precharge-all / auto-precharge select |
| cfg_cl25 | input | 1 | 1 = CAS latency 2.5, 0 = 2 |
| cfg_bl | input | 2 | Burst length code |
| viol_o | output | 12 | Per-rule violation flags |
| err_o | output | 1 | High when any flag is set |

## Verification
The embedded properties check several behaviours on every cycle. A deselected cycle never yields a flag. A column command to an idle bank always produces the illegal-state flag. A command right after a mode set always produces the gap flag. Auto-precharge and precharge leave the bank closed, while activate opens it. The timer cells never wrap below zero. The exact boundary of each spacing rule can only be shown by the directed scenarios: each is driven one cycle short of its minimum and then exactly at it. The dependence of the limits on burst length and CAS latency, and the choice between closing one bank and closing all, are likewise shown only by the scenarios.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

   typedef enum logic [2:0] {
      CMD_MRS = 3'b000,
      CMD_REF = 3'b001,
      CMD_PRE = 3'b010,
      CMD_ACT = 3'b011,
      CMD_WR  = 3'b100,
      CMD_RD  = 3'b101,
      CMD_BST = 3'b110,
      CMD_NOP = 3'b111
   } ddr_cmd_e;

   // violation vector bit positions
   localparam int V_RCD  = 0;
   localparam int V_RP   = 1;
   localparam int V_RAS  = 2;
   localparam int V_RC   = 3;
   localparam int V_RRD  = 4;
   localparam int V_WPRE = 5;
   localparam int V_RPRE = 6;
   localparam int V_WRD  = 7;
   localparam int V_RWR  = 8;
   localparam int V_MRD  = 9;
   localparam int V_ILL  = 10;
   localparam int V_DAL  = 11;
   localparam int NVIOL  = 12;

   // per-bank timer slots
   localparam int BT_RCD  = 0;
   localparam int BT_RAS  = 1;
   localparam int BT_RC   = 2;
   localparam int BT_RP   = 3;
   localparam int BT_WPRE = 4;
   localparam int BT_RPRE = 5;
   localparam int BT_DAL  = 6;
   localparam int NBT     = 7;

   // shared timer slots
   localparam int GT_WRD = 0;
   localparam int GT_RWR = 1;
   localparam int GT_RRD = 2;
   localparam int GT_MRD = 3;
   localparam int NGT    = 4;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/ddr_sat_timer.sv
module ddr_sat_timer #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         busy
);

   logic [W-1:0] cnt;
   logic [W-1:0] dec;

   if (W < 2) begin : g_bad_w
      $error("ddr_sat_timer: W must be at least 2");
   end

   assign dec  = (cnt != '0) ? cnt - 1'b1 : '0;
   assign busy = (cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= (val > dec) ? val : dec;
      else
         cnt <= dec;
   end

   AST_TMR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt == '0) |=> (cnt == '0)); // R14

   AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R14

endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
   import ddr_mon_pkg::*;
#(
   parameter int TMR_W = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        sel,
   input  logic                        act_cmd,
   input  logic                        rd_cmd,
   input  logic                        wr_cmd,
   input  logic                        pre_cmd,
   input  logic                        a10,
   input  logic [NBT-1:0][TMR_W-1:0]   ld_val,
   input  logic [TMR_W-1:0]            rdap_val,
   output logic                        is_open,
   output logic [NBT-1:0]              busy
);

   logic open_q;
   logic do_act, do_rd, do_wr, do_pre;
   logic [NBT-1:0]            ld;
   logic [NBT-1:0][TMR_W-1:0] val;

   assign do_act = act_cmd && sel && !open_q;
   assign do_rd  = rd_cmd  && sel && open_q;
   assign do_wr  = wr_cmd  && sel && open_q;
   assign do_pre = pre_cmd && open_q && (a10 || sel);

   always_comb begin
      val = ld_val;
      if (do_rd && a10)
         val[BT_RP] = rdap_val;
      ld          = '0;
      ld[BT_RCD]  = do_act;
      ld[BT_RAS]  = do_act;
      ld[BT_RC]   = do_act;
      ld[BT_RP]   = do_pre || (do_rd && a10);
      ld[BT_WPRE] = do_wr;
      ld[BT_RPRE] = do_rd;
      ld[BT_DAL]  = do_wr && a10;
   end

   for (genvar t = 0; t < NBT; t++) begin : g_tmr
      ddr_sat_timer #(.W(TMR_W)) u_tmr (
         .clk  (clk),
         .rst_n(rst_n),
         .load (ld[t]),
         .val  (val[t]),
         .busy (busy[t])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         open_q <= 1'b0;
      else if (do_act)
         open_q <= 1'b1;
      else if (do_pre || ((do_rd || do_wr) && a10))
         open_q <= 1'b0;
   end

   assign is_open = open_q;

   AST_AP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      ((do_rd || do_wr) && a10) |=> !is_open); // R12

   AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      do_pre |=> !is_open); // R12

   AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      do_act |=> is_open); // R13

endmodule

// File: rtl/ddr_cmd_timing_mon.sv
module ddr_cmd_timing_mon
   import ddr_mon_pkg::*;
#(
   parameter int TCK_PS      = 7500,
   parameter int TRCD_PS     = 20000,
   parameter int TRP_PS      = 20000,
   parameter int TRAS_PS     = 45000,
   parameter int TRC_PS      = 67500,
   parameter int TRRD_PS     = 15000,
   parameter int TWR_PS      = 15000,
   parameter int MRD_CK      = 2,
   parameter int FAST_TCK_PS = 7500,
   parameter int BA_W        = 2,
   parameter int TMR_W       = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BA_W-1:0]   ba,
   input  logic              a10,
   input  logic              cfg_cl25,
   input  logic [1:0]        cfg_bl,
   output logic [NVIOL-1:0]  viol_o,
   output logic              err_o
);

   localparam int NBANK     = 1 << BA_W;
   localparam int C_RCD     = ceil_div(TRCD_PS, TCK_PS);
   localparam int C_RP      = ceil_div(TRP_PS, TCK_PS);
   localparam int C_RAS     = ceil_div(TRAS_PS, TCK_PS);
   localparam int C_RC      = ceil_div(TRC_PS, TCK_PS);
   localparam int C_RRD     = ceil_div(TRRD_PS, TCK_PS);
   localparam int C_WR      = ceil_div(TWR_PS, TCK_PS);
   localparam int C_DAL     = C_WR + C_RP;
   localparam int WPRE_BASE = (TCK_PS < FAST_TCK_PS) ? 4 : 3;
   localparam int TMR_MAX   = (1 << TMR_W) - 1;
   localparam int LD_PEAK   = 1 + 4 + C_DAL + C_RP + WPRE_BASE + C_RC;

   // elaboration-time parameter checks
   if (TCK_PS <= 0) begin : g_bad_tck
      $error("ddr_cmd_timing_mon: TCK_PS must be positive");
   end
   if (BA_W < 1 || BA_W > 3) begin : g_bad_ba
      $error("ddr_cmd_timing_mon: BA_W out of range");
   end
   if (LD_PEAK > TMR_MAX) begin : g_bad_tmr
      $error("ddr_cmd_timing_mon: TMR_W too narrow for the timing set");
   end
   if (MRD_CK < 1) begin : g_bad_mrd
      $error("ddr_cmd_timing_mon: MRD_CK must be at least 1");
   end

   function automatic logic [TMR_W-1:0] m1(input int x);
      return (x > 0) ? TMR_W'(x - 1) : '0;
   endfunction

   // ---------------- command decode ----------------
   ddr_cmd_e  cmd;
   logic      cmd_vld;
   logic      is_act, is_rd, is_wr, is_pre, is_mrs, is_real;

   assign cmd     = ddr_cmd_e'({ras_n, cas_n, we_n});
   assign cmd_vld = !cs_n;
   assign is_act  = cmd_vld && (cmd == CMD_ACT);
   assign is_rd   = cmd_vld && (cmd == CMD_RD);
   assign is_wr   = cmd_vld && (cmd == CMD_WR);
   assign is_pre  = cmd_vld && (cmd == CMD_PRE);
   assign is_mrs  = cmd_vld && (cmd == CMD_MRS);
   assign is_real = cmd_vld && (cmd != CMD_NOP);

   // ---------------- configuration-dependent limits ----------------
   logic [3:0]       bl_half;
   logic [2:0]       cl_half;
   logic [TMR_W-1:0] bl_w, cl_w;
   logic [TMR_W-1:0] wpre_ld, rpre_ld, rdap_ld, dal_ld, wrd_ld, rwr_ld;

   always_comb begin
      case (cfg_bl)
         2'b10:   bl_half = 4'd2;
         2'b11:   bl_half = 4'd4;
         default: bl_half = 4'd1;
      endcase
   end

   // CL 2.5 carried as half-cycle count 5, rounded up for turnaround
   assign cl_half = cfg_cl25 ? 3'd5 : 3'd4;
   assign bl_w    = TMR_W'(bl_half);
   assign cl_w    = TMR_W'((cl_half + 3'd1) >> 1);
   assign wpre_ld = TMR_W'(WPRE_BASE) + bl_w - 1'b1;
   assign rpre_ld = bl_w - 1'b1;
   assign rdap_ld = bl_w + TMR_W'(C_RP) - 1'b1;
   assign dal_ld  = bl_w + TMR_W'(C_DAL);
   assign wrd_ld  = bl_w + 1'b1;
   assign rwr_ld  = bl_w + cl_w - 1'b1;

   logic [NBT-1:0][TMR_W-1:0] bank_ld;

   always_comb begin
      bank_ld          = '0;
      bank_ld[BT_RCD]  = m1(C_RCD);
      bank_ld[BT_RAS]  = m1(C_RAS);
      bank_ld[BT_RC]   = m1(C_RC);
      bank_ld[BT_RP]   = m1(C_RP);
      bank_ld[BT_WPRE] = wpre_ld;
      bank_ld[BT_RPRE] = rpre_ld;
      bank_ld[BT_DAL]  = dal_ld;
   end

   // ---------------- bank trackers ----------------
   logic [NBANK-1:0]          open_b;
   logic [NBANK-1:0][NBT-1:0] busy_b;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      ddr_bank_track #(.TMR_W(TMR_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .sel     (ba == BA_W'(b)),
         .act_cmd (is_act),
         .rd_cmd  (is_rd),
         .wr_cmd  (is_wr),
         .pre_cmd (is_pre),
         .a10     (a10),
         .ld_val  (bank_ld),
         .rdap_val(rdap_ld),
         .is_open (open_b[b]),
         .busy    (busy_b[b])
      );
   end

   // ---------------- shared timers ----------------
   logic                      tgt_open;
   logic                      act_real;
   logic [NGT-1:0]            g_ld;
   logic [NGT-1:0][TMR_W-1:0] g_val;
   logic [NGT-1:0]            g_busy;
   logic [BA_W-1:0]           last_act_ba;

   assign tgt_open = open_b[ba];
   assign act_real = is_act && !tgt_open;

   always_comb begin
      g_ld          = '0;
      g_val         = '0;
      g_ld[GT_WRD]  = is_wr && tgt_open;
      g_val[GT_WRD] = wrd_ld;
      g_ld[GT_RWR]  = is_rd && tgt_open;
      g_val[GT_RWR] = rwr_ld;
      g_ld[GT_RRD]  = act_real;
      g_val[GT_RRD] = m1(C_RRD);
      g_ld[GT_MRD]  = is_mrs;
      g_val[GT_MRD] = m1(MRD_CK);
   end

   for (genvar g = 0; g < NGT; g++) begin : g_shared
      ddr_sat_timer #(.W(TMR_W)) u_tmr (
         .clk  (clk),
         .rst_n(rst_n),
         .load (g_ld[g]),
         .val  (g_val[g]),
         .busy (g_busy[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         last_act_ba <= '0;
      else if (act_real)
         last_act_ba <= ba;
   end

   // ---------------- rule evaluation ----------------
   logic [NVIOL-1:0] flags;

   always_comb begin
      logic pre_ras, pre_wpre, pre_rpre;
      pre_ras  = 1'b0;
      pre_wpre = 1'b0;
      pre_rpre = 1'b0;
      for (int b = 0; b < NBANK; b++) begin
         if (open_b[b] && (a10 || ba == BA_W'(b))) begin
            pre_ras  = pre_ras  | busy_b[b][BT_RAS];
            pre_wpre = pre_wpre | busy_b[b][BT_WPRE];
            pre_rpre = pre_rpre | busy_b[b][BT_RPRE];
         end
      end
      flags         = '0;
      flags[V_RCD]  = (is_rd || is_wr) && tgt_open && busy_b[ba][BT_RCD];
      flags[V_RP]   = is_act && busy_b[ba][BT_RP];
      flags[V_RAS]  = (is_act && busy_b[ba][BT_RAS]) || (is_pre && pre_ras);
      flags[V_RC]   = is_act && busy_b[ba][BT_RC];
      flags[V_RRD]  = is_act && g_busy[GT_RRD] && (ba != last_act_ba);
      flags[V_WPRE] = is_pre && pre_wpre;
      flags[V_RPRE] = is_pre && pre_rpre;
      flags[V_WRD]  = is_rd && g_busy[GT_WRD];
      flags[V_RWR]  = is_wr && g_busy[GT_RWR];
      flags[V_MRD]  = is_real && g_busy[GT_MRD];
      flags[V_ILL]  = ((is_rd || is_wr) && !tgt_open) || (is_act && tgt_open);
      flags[V_DAL]  = is_act && busy_b[ba][BT_DAL];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         viol_o <= '0;
         err_o  <= 1'b0;
      end else begin
         viol_o <= flags;
         err_o  <= |flags;
      end
   end

   AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (viol_o == '0)); // R1

   AST_IDLE_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
      ((is_rd || is_wr) && !open_b[ba]) |=> viol_o[V_ILL]); // R13

   AST_MRD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (is_real && $past(is_mrs)) |=> viol_o[V_MRD]); // R10

endmodule

// File: tb/ddr_cmd_timing_mon_test.sv
module ddr_cmd_timing_mon_test;

   localparam int CLK_PERIOD = 10;

   localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010,
                          C_ACT = 3'b011, C_WR = 3'b100, C_RD = 3'b101,
                          C_NOP = 3'b111;
   localparam logic [11:0] F_RCD = 12'h001, F_RP = 12'h002, F_RAS = 12'h004,
                           F_RC = 12'h008, F_RRD = 12'h010, F_WPRE = 12'h020,
                           F_RPRE = 12'h040, F_WRD = 12'h080, F_RWR = 12'h100,
                           F_MRD = 12'h200, F_ILL = 12'h400, F_DAL = 12'h800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = 2'b00;
   logic        a10 = 1'b0;
   logic        cfg_cl25 = 1'b0;
   logic [1:0]  cfg_bl = 2'b10;
   logic [11:0] viol_o;
   logic        err_o;
   int          checks = 0;
   int          errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ddr_cmd_timing_mon uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .a10(a10), .cfg_cl25(cfg_cl25), .cfg_bl(cfg_bl),
      .viol_o(viol_o), .err_o(err_o)
   );

   // one command per cycle; on return viol_o shows its result
   task automatic issue(input logic [2:0] c, input int b, input logic ap, input logic desel = 1'b0);
      cs_n = desel;
      {ras_n, cas_n, we_n} = c;
      ba  = 2'(b);
      a10 = ap;
      @(negedge clk);
      cs_n = 1'b0;
      {ras_n, cas_n, we_n} = C_NOP;
      a10 = 1'b0;
   endtask

   task automatic nop(input int n);
      for (int i = 0; i < n; i++) issue(C_NOP, 0, 1'b0);
   endtask

   task automatic chk(input string req, input logic [11:0] exp);
      checks++;
      if (viol_o !== exp || err_o !== (exp != 12'h0)) begin
         errors++;
         $display("FAIL %s viol=%h err=%b expected viol=%h err=%b",
                  req, viol_o, err_o, exp, exp != 12'h0);
      end
   endtask

   task automatic settle();
      nop(20);
      issue(C_PRE, 0, 1'b1);
      nop(20);
   endtask

   task automatic t_reset();
      chk("R14 reset quiet", 12'h0);
   endtask

   task automatic t_rcd();
      issue(C_ACT, 1, 0); nop(1); issue(C_RD, 1, 0);
      chk("R3 read at 2 cycles after activate (R2 err strobe)", F_RCD);
      issue(C_RD, 2, 0);
      chk("R2 bank index selects other idle bank", F_ILL);
      settle();
      issue(C_ACT, 0, 0); nop(2); issue(C_RD, 0, 0);
      chk("R3 read at exact tRCD", 12'h0);
      settle();
   endtask

   task automatic t_ras();
      issue(C_ACT, 1, 0); nop(3); issue(C_PRE, 1, 0);
      chk("R5 precharge before tRAS", F_RAS);
      settle();
      issue(C_ACT, 2, 0); issue(C_ACT, 2, 0);
      chk("R5 R13 activate to open bank inside tRAS", F_ILL | F_RAS | F_RC);
      settle();
   endtask

   task automatic t_rp_rc();
      issue(C_ACT, 0, 0); nop(5); issue(C_PRE, 0, 0);
      chk("R5 precharge at exact tRAS", 12'h0);
      nop(1); issue(C_ACT, 0, 0);
      chk("R4 R6 early reactivate", F_RP | F_RC);
      settle();
      issue(C_ACT, 0, 0); nop(5); issue(C_PRE, 0, 0); nop(2); issue(C_ACT, 0, 0);
      chk("R4 R6 reactivate at exact limits", 12'h0);
      settle();
   endtask

   task automatic t_rrd();
      issue(C_ACT, 0, 0); issue(C_ACT, 1, 0);
      chk("R7 activate other bank too soon", F_RRD);
      settle();
      issue(C_ACT, 2, 0); nop(1); issue(C_ACT, 3, 0);
      chk("R7 activate other bank at tRRD", 12'h0);
      settle();
   endtask

   task automatic t_to_pre();
      issue(C_ACT, 0, 0); nop(2); issue(C_WR, 0, 0); nop(3); issue(C_PRE, 0, 0);
      chk("R8 write to precharge BL4", F_WPRE);
      settle();
      issue(C_ACT, 1, 0); nop(5); issue(C_RD, 1, 0); issue(C_PRE, 1, 0);
      chk("R8 read to precharge BL4", F_RPRE);
      settle();
      issue(C_ACT, 2, 0); nop(5); issue(C_RD, 2, 0); nop(1); issue(C_PRE, 2, 0);
      chk("R8 read to precharge at BL/2", 12'h0);
      settle();
      cfg_bl = 2'b11;
      issue(C_ACT, 3, 0); nop(5); issue(C_WR, 3, 0); nop(5); issue(C_PRE, 3, 0);
      chk("R8 R9 write to precharge BL8 at 6", F_WPRE);
      settle();
      cfg_bl = 2'b10;
   endtask

   task automatic t_turn();
      issue(C_ACT, 0, 0); nop(2); issue(C_WR, 0, 0); nop(2); issue(C_RD, 0, 0);
      chk("R9 write to read at 3", F_WRD);
      nop(10); issue(C_WR, 0, 0); nop(3); issue(C_RD, 0, 0);
      chk("R9 write to read at 4", 12'h0);
      nop(2); issue(C_WR, 0, 0);
      chk("R9 read to write CL2 at 3", F_RWR);
      nop(10); issue(C_RD, 0, 0); nop(3); issue(C_WR, 0, 0);
      chk("R9 read to write CL2 at 4", 12'h0);
      cfg_cl25 = 1'b1;
      nop(10); issue(C_RD, 0, 0); nop(3); issue(C_WR, 0, 0);
      chk("R9 read to write CL2.5 at 4", F_RWR);
      nop(10); issue(C_RD, 0, 0); nop(4); issue(C_WR, 0, 0);
      chk("R9 read to write CL2.5 at 5", 12'h0);
      cfg_cl25 = 1'b0;
      settle();
   endtask

   task automatic t_mrd();
      issue(C_MRS, 0, 0); issue(C_REF, 0, 0);
      chk("R10 refresh right after mode set", F_MRD);
      nop(5);
      issue(C_MRS, 0, 0); nop(1); issue(C_REF, 0, 0);
      chk("R10 refresh at mode-set gap", 12'h0);
      nop(5);
      issue(C_MRS, 0, 0); issue(C_ACT, 0, 0, 1'b1);
      chk("R1 deselected activate ignored", 12'h0);
      issue(C_REF, 0, 0);
      chk("R1 timer ran during deselect", 12'h0);
      issue(C_RD, 0, 0);
      chk("R1 bank stayed idle", F_ILL);
      settle();
   endtask

   task automatic t_autopre();
      issue(C_ACT, 1, 0); nop(2); issue(C_WR, 1, 1); issue(C_RD, 1, 0);
      chk("R12 write auto-precharge closed bank", F_ILL | F_WRD);
      nop(5); issue(C_ACT, 1, 0);
      chk("R11 activate inside write recovery", F_DAL);
      settle();
      issue(C_ACT, 1, 0); nop(2); issue(C_WR, 1, 1); nop(7); issue(C_ACT, 1, 0);
      chk("R11 activate at exact auto-precharge delay", 12'h0);
      settle();
      issue(C_ACT, 2, 0); nop(5); issue(C_RD, 2, 1); nop(3); issue(C_ACT, 2, 0);
      chk("R4 activate inside read auto-precharge", F_RP);
      settle();
   endtask

   task automatic t_prechg();
      issue(C_ACT, 0, 0); nop(1); issue(C_ACT, 1, 0); nop(8); issue(C_PRE, 0, 1);
      chk("R12 precharge all", 12'h0);
      issue(C_RD, 0, 0);
      chk("R12 bank 0 closed by all", F_ILL);
      issue(C_RD, 1, 0);
      chk("R12 bank 1 closed by all", F_ILL);
      nop(5);
      issue(C_ACT, 2, 0); nop(1); issue(C_ACT, 3, 0); nop(8); issue(C_PRE, 2, 0);
      chk("R12 single precharge", 12'h0);
      issue(C_RD, 3, 0);
      chk("R12 other bank stays open", 12'h0);
      issue(C_RD, 2, 0);
      chk("R12 addressed bank closed", F_ILL);
      settle();
   endtask

   task automatic t_illegal();
      issue(C_WR, 1, 0);
      chk("R13 write to idle bank", F_ILL);
      nop(100);
      issue(C_ACT, 1, 0);
      chk("R14 timers saturate over long idle", 12'h0);
      settle();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cs_n  = 1'b0;
      @(negedge clk);
      t_reset();
      t_rcd();
      t_ras();
      t_rp_rc();
      t_rrd();
      t_to_pre();
      t_turn();
      t_mrd();
      t_autopre();
      t_prechg();
      t_illegal();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule